// File: doc/BRIEF.md
# Three-Phase Waveform Snapshot Register with Data-Ready Interrupt

This block takes three filtered, 24-bit signed voltage sample streams that share one valid strobe. It copies one sample per phase into holding registers that software can read. The valid strobe is a clock enable that fires once per output sample period, for example 8 kHz derived from the system clock. It is not a separate clock. On every strobe the block captures all three phases in the same clock edge. It never pushes back on the producer, so the power and rms computations that consume the same stream keep running.

Each capture sets a ready flag at bit 17 of a status word. A mask word enables that flag, at the same bit position, onto an active-low interrupt line. Software reads the held samples as 32-bit words with the sign extended. It clears the flag by writing a one to bit 17 of the status word. If a new capture falls in the same cycle as that clear, the flag stays set, so no sample set is lost silently.

Top module: `wfm_snapshot`

## Requirements
- R1: After reset, all held samples are 0, the ready flag and the mask bit are 0, `irq_n` is 1 and `rd_data` is 0.
- R2: In a cycle with `smp_valid` high, the three held samples all take the values on `smp_in` at that clock edge. Phase p is taken from bits [24p+23:24p]. In cycles with `smp_valid` low, the held samples do not change, whatever `smp_in` carries.
- R3: A strobe is captured in every cycle it is present, including back-to-back cycles. The block has no stall or ready output toward the sample source.
- R4: Reading address p (0, 1 or 2) returns held sample p with bit 23 copied into bits 31:24. `rd_data` changes one edge after the read and shows the value the register held before that edge. Without a read, `rd_data` keeps its last value.
- R5: Reading address 3 returns the status word. Bit 17 of that word is the ready flag and all other bits are 0. The flag sets on every capture.
- R6: A write to address 3 with bit 17 of `wr_data` set clears the ready flag. A write to address 3 with bit 17 clear leaves the flag unchanged.
- R7: When a capture and a clearing write to address 3 fall in the same cycle, the ready flag remains set.
- R8: A write to address 4 loads the mask bit from `wr_data` bit 17. Reading address 4 returns the mask bit at bit 17, with all other bits 0.
- R9: `irq_n` is 0 exactly when the ready flag and the mask bit are both set. It follows them without further delay after the edge that updates them.
- R10: Reads of addresses 5, 6 and 7 return 0. Writes to addresses 0 to 2 and 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample-period enable strobe, common to all phases |
| smp_in | input | 72 | Three packed 24-bit signed samples, phase 0 in the low bits |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Read address (0-2 samples, 3 status, 4 mask) |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Write request |
| wr_addr | input | 3 | Write address (3 status clear, 4 mask) |
| wr_data | input | 32 | Write data; only bit 17 is used |
| irq_n | output | 1 | Active-low interrupt, ready flag AND mask bit |

## Verification
The assertions check on every cycle that:
- every strobe copies all three phases and a quiet cycle holds them;
- a capture always leaves the flag set, and a clear without a capture drops it;
- the flag never rises without a capture;
- a masked capture pulls `irq_n` low on the next edge;
- sample reads come back sign-extended, unmapped reads return zero, and `rd_data` holds between reads.

Only the bench's scenarios can show the rest. These cover:
- the full values seen through the read port, including the old-value result of a read that coincides with a capture;
- the outcome of a capture and a clear in the same cycle;
- writes that must be ignored;
- long stretches of randomly mixed captures, reads, clears and mask changes.

In those scenarios a behavioural model predicts `rd_data` and `irq_n` on every clock.

// File: rtl/wfm_pkg.sv
package wfm_pkg;

    localparam int SMP_W_DEF   = 24;
    localparam int WORD_W_DEF  = 32;
    localparam int NPH_DEF     = 3;
    localparam int RDY_POS_DEF = 17;
    localparam int ADDR_W_DEF  = 3;

    // flag and its enable, registered together
    typedef struct packed {
        logic ready;
        logic enable;
    } rdy_state_t;

    // what a read address selects
    typedef enum logic [1:0] {
        SEL_SAMPLE,
        SEL_STATUS,
        SEL_MASK,
        SEL_NONE
    } rd_sel_e;

endpackage

// File: rtl/wfm_sample_bank.sv
module wfm_sample_bank #(
    parameter int NPH   = wfm_pkg::NPH_DEF,
    parameter int SMP_W = wfm_pkg::SMP_W_DEF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cap,
    input  logic [NPH*SMP_W-1:0]            smp_in,
    output logic [NPH-1:0][SMP_W-1:0]       held
);

    typedef struct packed {
        logic [NPH-1:0][SMP_W-1:0] smp;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (cap) begin
            for (int p = 0; p < NPH; p++) begin
                bank_d.smp[p] = smp_in[p*SMP_W +: SMP_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign held = bank_q.smp;

    // one capture and one hold check per phase
    for (genvar g = 0; g < NPH; g++) begin : g_phase_chk
        assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cap |=> (held[g] == $past(smp_in[g*SMP_W +: SMP_W])));
        assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !cap |=> $stable(held[g]));
    end

endmodule

// File: rtl/wfm_status.sv
module wfm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic clr,
    input  logic mask_we,
    input  logic mask_val,
    output logic ready,
    output logic enable,
    output logic irq_n
);

    import wfm_pkg::*;

    rdy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.enable = mask_val;
        end
        // a capture outranks a clear in the same cycle
        if (cap) begin
            st_d.ready = 1'b1;
        end else if (clr) begin
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready  = st_q.ready;
    assign enable = st_q.enable;
    assign irq_n  = ~(st_q.ready & st_q.enable);

    assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> ready);
    assert_noset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !ready) |=> !ready);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !cap) |=> !ready);
    assert_race_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && cap) |=> ready);
    assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (enable == $past(mask_val)));
    assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && enable && !mask_we) |=> !irq_n);
    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !mask_we) |=> irq_n);

endmodule

// File: rtl/wfm_read_port.sv
module wfm_read_port #(
    parameter int NPH     = wfm_pkg::NPH_DEF,
    parameter int SMP_W   = wfm_pkg::SMP_W_DEF,
    parameter int WORD_W  = wfm_pkg::WORD_W_DEF,
    parameter int RDY_POS = wfm_pkg::RDY_POS_DEF,
    parameter int ADDR_W  = wfm_pkg::ADDR_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [NPH-1:0][SMP_W-1:0]  held,
    input  logic                       ready,
    input  logic                       enable,
    output logic [WORD_W-1:0]          rd_data
);

    import wfm_pkg::*;

    localparam int                EXT_W     = WORD_W - SMP_W;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NPH);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NPH + 1);

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } rd_state_t;

    rd_state_t rs_d, rs_q;
    rd_sel_e   sel;
    logic [WORD_W-1:0] word;

    function automatic logic [WORD_W-1:0] widen(input logic [SMP_W-1:0] s);
        return {{EXT_W{s[SMP_W-1]}}, s};
    endfunction

    always_comb begin
        if (rd_addr < STAT_ADDR) begin
            sel = SEL_SAMPLE;
        end else if (rd_addr == STAT_ADDR) begin
            sel = SEL_STATUS;
        end else if (rd_addr == MASK_ADDR) begin
            sel = SEL_MASK;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        word = '0;
        unique case (sel)
            SEL_SAMPLE: begin
                for (int p = 0; p < NPH; p++) begin
                    if (rd_addr == ADDR_W'(p)) begin
                        word = widen(held[p]);
                    end
                end
            end
            SEL_STATUS: word[RDY_POS] = ready;
            SEL_MASK:   word[RDY_POS] = enable;
            default:    word = '0;
        endcase
    end

    always_comb begin
        rs_d = rs_q;
        if (rd_en) begin
            rs_d.data = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rd_data = rs_q.data;

    assert_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr < STAT_ADDR)) |=>
            ((rd_data[WORD_W-1:SMP_W-1] == '0) || (rd_data[WORD_W-1:SMP_W-1] == '1)));
    assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr > MASK_ADDR)) |=> (rd_data == '0));

endmodule

// File: rtl/wfm_snapshot.sv
module wfm_snapshot #(
    parameter int NPH     = wfm_pkg::NPH_DEF,
    parameter int SMP_W   = wfm_pkg::SMP_W_DEF,
    parameter int WORD_W  = wfm_pkg::WORD_W_DEF,
    parameter int RDY_POS = wfm_pkg::RDY_POS_DEF,
    parameter int ADDR_W  = wfm_pkg::ADDR_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic [NPH*SMP_W-1:0]  smp_in,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [WORD_W-1:0]     rd_data,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    output logic                  irq_n
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NPH);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NPH + 1);

    logic [NPH-1:0][SMP_W-1:0] held;
    logic ready, enable;
    logic clr, mask_we, mask_val;
    logic wr_unused;

    // write decode: only bit RDY_POS of the data carries meaning
    always_comb begin
        clr      = wr_en && (wr_addr == STAT_ADDR) && wr_data[RDY_POS];
        mask_we  = wr_en && (wr_addr == MASK_ADDR);
        mask_val = wr_data[RDY_POS];
    end

    assign wr_unused = ^wr_data;

    wfm_sample_bank #(.NPH(NPH), .SMP_W(SMP_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (smp_valid),
        .smp_in (smp_in),
        .held   (held)
    );

    wfm_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (smp_valid),
        .clr      (clr),
        .mask_we  (mask_we),
        .mask_val (mask_val),
        .ready    (ready),
        .enable   (enable),
        .irq_n    (irq_n)
    );

    wfm_read_port #(
        .NPH(NPH), .SMP_W(SMP_W), .WORD_W(WORD_W),
        .RDY_POS(RDY_POS), .ADDR_W(ADDR_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .held    (held),
        .ready   (ready),
        .enable  (enable),
        .rd_data (rd_data)
    );

    assert_reset_R1: assert property (@(posedge clk) !rst_n |=> (irq_n && (rd_data == '0)));

endmodule

// File: tb/wfm_snapshot_tb.sv
module wfm_snapshot_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [71:0] smp_in = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        irq_n;

    always #10 clk = ~clk;   // 50 MHz

    wfm_snapshot u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_n(irq_n)
    );

    int    nchk = 0;
    int    nerr = 0;
    int    ncyc = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1 reset";
    string m_tag = "R1 reset";

    // behavioural reference state
    logic [23:0] m_held [3];
    bit          m_flag, m_mask;
    logic [31:0] m_rd;

    function automatic logic [31:0] model_read(input logic [2:0] a);
        logic [31:0] w;
        w = '0;
        case (a)
            3'd0, 3'd1, 3'd2: w = {{8{m_held[a][23]}}, m_held[a]};
            3'd3: w[17] = m_flag;
            3'd4: w[17] = m_mask;
            default: w = '0;
        endcase
        return w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m_held[i] = '0;
            m_flag = 1'b0;
            m_mask = 1'b0;
            m_rd   = '0;
        end else begin
            if (rd_en) begin
                m_rd  = model_read(rd_addr);
                m_tag = cur_tag;
            end
            if (wr_en && wr_addr == 3'd4) m_mask = wr_data[17];
            if (smp_valid) m_flag = 1'b1;
            else if (wr_en && wr_addr == 3'd3 && wr_data[17]) m_flag = 1'b0;
            if (smp_valid) begin
                for (int i = 0; i < 3; i++) m_held[i] = smp_in[i*24 +: 24];
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            nchk++;
            if (rd_data !== m_rd) begin
                nerr++;
                $display("FAIL %s: rd_data got %h expected %h", m_tag, rd_data, m_rd);
            end
            nchk++;
            if (irq_n !== ~(m_flag & m_mask)) begin
                nerr++;
                $display("FAIL R9: irq_n got %b expected %b", irq_n, ~(m_flag & m_mask));
            end
        end
    end

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 100000 && !done) begin
            done = 1'b1;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic op(input bit v, input logic [71:0] s,
                      input bit re, input logic [2:0] ra,
                      input bit we, input logic [2:0] wa, input logic [31:0] wd);
        smp_valid = v; smp_in = s;
        rd_en = re; rd_addr = ra;
        wr_en = we; wr_addr = wa; wr_data = wd;
        tick();
        smp_valid = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        op(1'b0, smp_in, 1'b1, a, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic cap(input logic [23:0] a, input logic [23:0] b, input logic [23:0] c);
        op(1'b1, {c, b, a}, 1'b0, 3'd0, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        op(1'b0, smp_in, 1'b0, 3'd0, 1'b1, a, d);
    endtask

    task automatic read_all();
        for (int a = 0; a < 5; a++) rd(3'(a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        nchk++;
        if (rd_data !== 32'd0 || irq_n !== 1'b1) begin
            nerr++;
            $display("FAIL R1: rd_data/irq_n got %h/%b expected 0/1", rd_data, irq_n);
        end
        rst_n = 1'b1;
        chk_on = 1'b1;
        cur_tag = "R1 after reset";
        read_all();

        cur_tag = "R2 capture";
        cap(24'h123456, 24'hABCDEF, 24'h000001);
        read_all();
        cur_tag = "R2 hold without strobe";
        smp_in = {24'h111111, 24'h222222, 24'h333333};
        tick(); tick();
        read_all();

        cur_tag = "R4 sign extension";
        cap(24'h800000, 24'h7FFFFF, 24'hFFFFFF);
        read_all();
        // read colliding with capture returns the old value
        op(1'b1, {24'h0, 24'h0, 24'h400000}, 1'b1, 3'd0, 1'b0, 3'd0, 32'd0);
        rd(3'd0);

        cur_tag = "R3 back-to-back strobes";
        for (int k = 0; k < 6; k++) begin
            op(1'b1, {24'(k * 3 + 2), 24'(k * 3 + 1), 24'(24'hF00000 + k)},
               1'b1, 3'(k % 3), 1'b0, 3'd0, 32'd0);
        end
        read_all();

        cur_tag = "R6 clear flag";
        wr(3'd3, 32'hFFFD_FFFF);       // bit 17 clear: no effect
        rd(3'd3);
        wr(3'd3, 32'h0002_0000);       // bit 17 set: clears
        rd(3'd3);

        cur_tag = "R8 mask";
        wr(3'd4, 32'h0002_0000);
        rd(3'd4);
        cur_tag = "R5 status set, R9 irq";
        cap(24'h0A0A0A, 24'h0B0B0B, 24'h0C0C0C);
        rd(3'd3);
        cur_tag = "R7 capture wins over clear";
        op(1'b1, {24'h1, 24'h2, 24'h3}, 1'b0, 3'd0, 1'b1, 3'd3, 32'h0002_0000);
        rd(3'd3);
        cur_tag = "R6 clear drops irq";
        wr(3'd3, 32'h0002_0000);
        rd(3'd3);
        cur_tag = "R8 mask other bits";
        wr(3'd4, 32'hFFFD_FFFF);
        rd(3'd4);
        cap(24'h5, 24'h6, 24'h7);
        rd(3'd3);

        cur_tag = "R10 unmapped and ignored writes";
        for (int a = 5; a < 8; a++) rd(3'(a));
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        read_all();

        cur_tag = "random R2/R5/R6/R7/R9";
        for (int k = 0; k < 2000; k++) begin
            op(($urandom % 4) == 0, 72'({$urandom(), $urandom(), $urandom()}),
               ($urandom % 2) == 0, 3'($urandom % 8),
               ($urandom % 5) == 0, 3'($urandom % 8),
               (($urandom % 2) == 0) ? 32'h0002_0000 : 32'h0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule